// File: doc/BRIEF.md
# BCD/Binary Calendar Counter with Wildcard Alarm

This block holds a full wall-clock date: seconds, minutes, hours, day of week, day of month, month, two-digit year and century. Each field is one byte. On every accepted one-second strobe it moves the whole date forward by one second, and the carry runs from seconds all the way to the century in that same strobe. Two live format inputs set how the bytes are read and written. One picks packed decimal (tens nibble and ones nibble) or plain binary. The other picks a 24-hour clock or a 12-hour clock with a PM flag.

Three alarm bytes, for seconds, minutes and hours, are compared against the time that each update produces. An alarm byte with its two top bits both set is a wildcard and matches every value. A freeze input stops the clock so that software can load a consistent time through the byte write port. Each accepted update gives a one-cycle update pulse. A matching alarm gives a one-cycle alarm pulse at the same time.

Top module: `rtc_calendar_core`

## Requirements
- R1: Synchronous reset (rst=1) loads 00:00:00, day of week 1, day of month 1, month 1, year RST_YEAR and century RST_CENTURY. Each value is encoded using the format inputs present during reset. Reset clears all three alarm bytes to 0x00 and drives both pulses low.
- R2: With fmt_binary=0 a field is stored as tens in bits 7:4 and ones in bits 3:0. With fmt_binary=1 it is stored as the plain binary value. Seconds count 0 to 59 and wrap to 0 with a carry into minutes.
- R3: Minutes wrap from 59 to 0 with a carry into hours. In 24-hour form (fmt_24h=1) hours wrap from 23 to 0 with a carry into the date.
- R4: In 12-hour form (fmt_24h=0) the hour byte holds 1 to 12 in bits 6:0 and bit 7 marks PM. The hour after 11 AM is 12 PM. The hour after 11 PM is 12 AM, and that step carries into the date.
- R5: Day of week counts 1 to 7 and returns to 1 on each day carry.
- R6: Day of month wraps to 1 with a month carry after its last day. That last day is 31 for months 1, 3, 5, 7, 8, 10 and 12, and 30 for months 4, 6, 9 and 11. For month 2 it is 29 when the year value is divisible by 4 and 28 otherwise.
- R7: Month wraps from 12 to 1 with a year carry. Year wraps from 99 to 0 with a century carry. Century wraps from 99 to 0. The full chain settles in a single strobe.
- R8: While set_mode=1, strobes leave the time fields unchanged and produce no update pulse. Bytes written in set mode are kept until set mode ends.
- R9: When wr_en=1, wr_data goes into the byte picked by wr_sel and shows at the outputs from the next cycle on. The wr_sel codes are 0 second, 1 minute, 2 hour, 3 day of week, 4 day of month, 5 month, 6 year, 7 century, 8 alarm second, 9 alarm minute and 10 alarm hour. Codes 11 to 15 change nothing.
- R10: An accepted strobe (tick=1, set_mode=0) makes update_pulse high for exactly one cycle. That cycle is the first one in which the new time is visible.
- R11: An alarm byte whose bits 7:6 are 11 is a wildcard. alarm_pulse rises together with update_pulse when every alarm field that is not a wildcard equals the new time. When all three alarm bytes are wildcards, every update raises alarm_pulse.
- R12: The alarm hour is decoded in the same 12-hour or 24-hour form as the current hour, PM bit included. An alarm at 1 PM therefore matches 1 PM and does not match 1 AM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-second strobe |
| fmt_binary | input | 1 | 1 = plain binary bytes, 0 = packed decimal |
| fmt_24h | input | 1 | 1 = 24-hour form, 0 = 12-hour with PM bit |
| set_mode | input | 1 | Freezes counting while high |
| wr_en | input | 1 | Byte write enable |
| wr_sel | input | 4 | Byte select for writes |
| wr_data | input | 8 | Write data |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours (bit 7 = PM in 12-hour form) |
| wday_o | output | 8 | Day of week |
| mday_o | output | 8 | Day of month |
| month_o | output | 8 | Month |
| year_o | output | 8 | Year within century |
| century_o | output | 8 | Century |
| alm_sec_o | output | 8 | Alarm seconds byte |
| alm_min_o | output | 8 | Alarm minutes byte |
| alm_hour_o | output | 8 | Alarm hours byte |
| update_pulse | output | 1 | One-cycle pulse per accepted update |
| alarm_pulse | output | 1 | One-cycle pulse on an alarm match |

## Verification
The bench builds the block with RST_YEAR=99 and RST_CENTURY=20. The date after reset is therefore one year carry away from a century rollover, and the reset check sees a two-digit year that differs between the two encodings. Directed cases then load year 99, December 31 23:59:59 and the February ends of leap and common years to reach the deepest carries. Random rounds change both format inputs and load times close to each boundary, so the 12-hour PM transitions and the alarm wildcards are covered in both encodings.

// File: rtl/rtcc_pkg.sv
`timescale 1ns/1ps
package rtcc_pkg;
    localparam int BYTE_W = 8;
    localparam int SEL_W  = 4;
    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [SEL_W-1:0] {
        SEL_SEC   = 4'd0,  SEL_MIN   = 4'd1,  SEL_HOUR  = 4'd2,
        SEL_WDAY  = 4'd3,  SEL_MDAY  = 4'd4,  SEL_MON   = 4'd5,
        SEL_YEAR  = 4'd6,  SEL_CENT  = 4'd7,  SEL_ASEC  = 4'd8,
        SEL_AMIN  = 4'd9,  SEL_AHOUR = 4'd10
    } field_sel_e;

    typedef struct packed {
        byte_t sec; byte_t min; byte_t hour; byte_t wday;
        byte_t mday; byte_t mon; byte_t year; byte_t cent;
    } cal_t;

    typedef struct packed {
        byte_t sec; byte_t min; byte_t hour;
    } alarm_t;

    localparam byte_t PM_FLAG  = 8'h80;
    localparam byte_t HOUR_VAL = 8'h7F;

    // stored byte -> plain value
    function automatic byte_t to_bin(byte_t v, logic bin);
        return bin ? v : byte_t'(({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]});
    endfunction

    // plain value (0..99) -> stored byte
    function automatic byte_t from_bin(byte_t v, logic bin);
        return bin ? v : byte_t'(((v / 8'd10) << 4) | (v % 8'd10));
    endfunction

    // stored hour byte -> 0..23
    function automatic byte_t hour_to24(byte_t v, logic bin, logic h24);
        byte_t h;
        h = to_bin(v & HOUR_VAL, bin);
        if (h24) return to_bin(v, bin);
        return v[7] ? (h % 8'd12) + 8'd12 : (h % 8'd12);
    endfunction

    // 0..23 -> stored hour byte
    function automatic byte_t hour_from24(byte_t h, logic bin, logic h24);
        byte_t hh;
        if (h24) return from_bin(h, bin);
        hh = h % 8'd12;
        if (hh == 8'd0) hh = 8'd12;
        return from_bin(hh, bin) | ((h >= 8'd12) ? PM_FLAG : 8'h00);
    endfunction

    function automatic byte_t month_len(byte_t m, byte_t y);
        case (m)
            8'd2:                      return ((y % 8'd4) == 8'd0) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11:   return 8'd30;
            default:                   return 8'd31;
        endcase
    endfunction

    function automatic logic is_wild(byte_t v);
        return v[7:6] == 2'b11;
    endfunction
endpackage

// File: rtl/rtcc_advance.sv
`timescale 1ns/1ps
module rtcc_advance
    import rtcc_pkg::*;
(
    input  cal_t cur,
    input  logic fmt_bin,
    input  logic fmt_24h,
    output cal_t nxt
);
    byte_t s, m, h, w, d, mo, y, c;
    logic  c_min, c_hour, c_day, c_mon, c_year, c_cent;

    always_comb begin
        s  = to_bin(cur.sec,  fmt_bin);
        m  = to_bin(cur.min,  fmt_bin);
        h  = hour_to24(cur.hour, fmt_bin, fmt_24h);
        w  = to_bin(cur.wday, fmt_bin);
        d  = to_bin(cur.mday, fmt_bin);
        mo = to_bin(cur.mon,  fmt_bin);
        y  = to_bin(cur.year, fmt_bin);
        c  = to_bin(cur.cent, fmt_bin);

        // carry chain, all resolved within one strobe
        c_min  = s >= 8'd59;
        c_hour = c_min  && (m >= 8'd59);
        c_day  = c_hour && (h >= 8'd23);
        c_mon  = c_day  && (d >= month_len(mo, y));
        c_year = c_mon  && (mo >= 8'd12);
        c_cent = c_year && (y >= 8'd99);

        nxt      = cur;
        nxt.sec  = from_bin(c_min ? 8'd0 : s + 8'd1, fmt_bin);
        if (c_min)  nxt.min  = from_bin(c_hour ? 8'd0 : m + 8'd1, fmt_bin);
        if (c_hour) nxt.hour = hour_from24(c_day ? 8'd0 : h + 8'd1, fmt_bin, fmt_24h);
        if (c_day) begin
            nxt.wday = from_bin((w >= 8'd7) ? 8'd1 : w + 8'd1, fmt_bin);
            nxt.mday = from_bin(c_mon ? 8'd1 : d + 8'd1, fmt_bin);
        end
        if (c_mon)  nxt.mon  = from_bin(c_year ? 8'd1 : mo + 8'd1, fmt_bin);
        if (c_year) nxt.year = from_bin(c_cent ? 8'd0 : y + 8'd1, fmt_bin);
        if (c_cent) nxt.cent = from_bin((c >= 8'd99) ? 8'd0 : c + 8'd1, fmt_bin);
    end
endmodule

// File: rtl/rtcc_alarm.sv
`timescale 1ns/1ps
module rtcc_alarm
    import rtcc_pkg::*;
(
    input  alarm_t alm,
    input  byte_t  sec,
    input  byte_t  min,
    input  byte_t  hour,
    input  logic   fmt_bin,
    input  logic   fmt_24h,
    output logic   hit
);
    logic sec_ok, min_ok, hour_ok;

    always_comb begin
        sec_ok  = is_wild(alm.sec) || (to_bin(alm.sec, fmt_bin) == to_bin(sec, fmt_bin));
        min_ok  = is_wild(alm.min) || (to_bin(alm.min, fmt_bin) == to_bin(min, fmt_bin));
        hour_ok = is_wild(alm.hour) ||
                  (hour_to24(alm.hour, fmt_bin, fmt_24h) == hour_to24(hour, fmt_bin, fmt_24h));
        hit     = sec_ok && min_ok && hour_ok;
    end
endmodule

// File: rtl/rtc_calendar_core.sv
`timescale 1ns/1ps
module rtc_calendar_core
    import rtcc_pkg::*;
#(
    parameter int unsigned RST_YEAR    = 0,
    parameter int unsigned RST_CENTURY = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             fmt_binary,
    input  logic             fmt_24h,
    input  logic             set_mode,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_data,
    output logic [7:0]       sec_o,
    output logic [7:0]       min_o,
    output logic [7:0]       hour_o,
    output logic [7:0]       wday_o,
    output logic [7:0]       mday_o,
    output logic [7:0]       month_o,
    output logic [7:0]       year_o,
    output logic [7:0]       century_o,
    output logic [7:0]       alm_sec_o,
    output logic [7:0]       alm_min_o,
    output logic [7:0]       alm_hour_o,
    output logic             update_pulse,
    output logic             alarm_pulse
);
    cal_t   cal_q, cal_adv, cal_d, cal_rst;
    alarm_t alm_q, alm_d;
    logic   step, hit, upd_q, alm_pulse_q;

    assign step = tick && !set_mode;

    rtcc_advance u_adv (
        .cur(cal_q), .fmt_bin(fmt_binary), .fmt_24h(fmt_24h), .nxt(cal_adv)
    );

    always_comb begin
        cal_d = step ? cal_adv : cal_q;
        alm_d = alm_q;
        if (wr_en) begin
            case (field_sel_e'(wr_sel))
                SEL_SEC:   cal_d.sec  = wr_data;
                SEL_MIN:   cal_d.min  = wr_data;
                SEL_HOUR:  cal_d.hour = wr_data;
                SEL_WDAY:  cal_d.wday = wr_data;
                SEL_MDAY:  cal_d.mday = wr_data;
                SEL_MON:   cal_d.mon  = wr_data;
                SEL_YEAR:  cal_d.year = wr_data;
                SEL_CENT:  cal_d.cent = wr_data;
                SEL_ASEC:  alm_d.sec  = wr_data;
                SEL_AMIN:  alm_d.min  = wr_data;
                SEL_AHOUR: alm_d.hour = wr_data;
                default: ;
            endcase
        end
    end

    // compare against the time that this update stores
    rtcc_alarm u_alm (
        .alm(alm_q), .sec(cal_d.sec), .min(cal_d.min), .hour(cal_d.hour),
        .fmt_bin(fmt_binary), .fmt_24h(fmt_24h), .hit(hit)
    );

    always_comb begin
        cal_rst      = '0;
        cal_rst.sec  = from_bin(8'd0, fmt_binary);
        cal_rst.min  = from_bin(8'd0, fmt_binary);
        cal_rst.hour = hour_from24(8'd0, fmt_binary, fmt_24h);
        cal_rst.wday = from_bin(8'd1, fmt_binary);
        cal_rst.mday = from_bin(8'd1, fmt_binary);
        cal_rst.mon  = from_bin(8'd1, fmt_binary);
        cal_rst.year = from_bin(byte_t'(RST_YEAR), fmt_binary);
        cal_rst.cent = from_bin(byte_t'(RST_CENTURY), fmt_binary);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q       <= cal_rst;
            alm_q       <= '0;
            upd_q       <= 1'b0;
            alm_pulse_q <= 1'b0;
        end else begin
            cal_q       <= cal_d;
            alm_q       <= alm_d;
            upd_q       <= step;
            alm_pulse_q <= step && hit;
        end
    end

    assign sec_o        = cal_q.sec;
    assign min_o        = cal_q.min;
    assign hour_o       = cal_q.hour;
    assign wday_o       = cal_q.wday;
    assign mday_o       = cal_q.mday;
    assign month_o      = cal_q.mon;
    assign year_o       = cal_q.year;
    assign century_o    = cal_q.cent;
    assign alm_sec_o    = alm_q.sec;
    assign alm_min_o    = alm_q.min;
    assign alm_hour_o   = alm_q.hour;
    assign update_pulse = upd_q;
    assign alarm_pulse  = alm_pulse_q;

    AST_UPD_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick && !set_mode) |=> update_pulse); // R10
    AST_SET_NO_UPD: assert property (@(posedge clk) disable iff (rst)
        set_mode |=> !update_pulse); // R8
    AST_SET_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (set_mode && !wr_en) |=> $stable(cal_q)); // R8
    AST_ALM_WITH_UPD: assert property (@(posedge clk) disable iff (rst)
        alarm_pulse |-> update_pulse); // R11
    AST_ALL_WILD: assert property (@(posedge clk) disable iff (rst)
        (tick && !set_mode && !wr_en && is_wild(alm_q.sec) && is_wild(alm_q.min)
         && is_wild(alm_q.hour)) |=> alarm_pulse); // R11
    AST_WDAY_RANGE: assert property (@(posedge clk) disable iff (rst)
        (tick && !set_mode && !wr_en && cal_q.wday >= 8'd1 && cal_q.wday <= 8'd7)
        |=> (wday_o >= 8'd1 && wday_o <= 8'd7)); // R5
endmodule

// File: tb/tb_rtc_calendar_core.sv
`timescale 1ns/1ps
module tb_rtc_calendar_core;
    logic clk = 1'b0, rst = 1'b1, tick = 1'b0;
    logic fmt_binary = 1'b0, fmt_24h = 1'b1, set_mode = 1'b0, wr_en = 1'b0;
    logic [3:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, month_o, year_o, century_o;
    logic [7:0] alm_sec_o, alm_min_o, alm_hour_o;
    logic update_pulse, alarm_pulse;

    rtc_calendar_core #(.RST_YEAR(99), .RST_CENTURY(20)) dut (.*);

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0;
    int m_sec, m_min, m_hr, m_wday, m_mday, m_mon, m_yr, m_cen;
    int a_sec, a_min, a_hr;          // -1 = wildcard
    logic [7:0] b_asec, b_amin, b_ahr;

    function automatic int enc(int v);
        return fmt_binary ? v : (((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int enc_hour(int h);
        int hh;
        if (fmt_24h) return enc(h);
        hh = (h % 12 == 0) ? 12 : h % 12;
        return enc(hh) | ((h >= 12) ? 128 : 0);
    endfunction

    function automatic int days_in(int mo, int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        chk(req, "sec",   sec_o,     enc(m_sec));
        chk(req, "min",   min_o,     enc(m_min));
        chk(req, "hour",  hour_o,    enc_hour(m_hr));
        chk(req, "wday",  wday_o,    enc(m_wday));
        chk(req, "mday",  mday_o,    enc(m_mday));
        chk(req, "month", month_o,   enc(m_mon));
        chk(req, "year",  year_o,    enc(m_yr));
        chk(req, "cent",  century_o, enc(m_cen));
        chk(req, "asec",  alm_sec_o, b_asec);
        chk(req, "amin",  alm_min_o, b_amin);
        chk(req, "ahour", alm_hour_o, b_ahr);
    endtask

    task automatic model_step();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hr++;
                if (m_hr == 24) begin
                    m_hr = 0;
                    m_wday = (m_wday == 7) ? 1 : m_wday + 1;
                    m_mday++;
                    if (m_mday > days_in(m_mon, m_yr)) begin
                        m_mday = 1; m_mon++;
                        if (m_mon == 13) begin
                            m_mon = 1; m_yr++;
                            if (m_yr == 100) begin m_yr = 0; m_cen = (m_cen + 1) % 100; end
                        end
                    end
                end
            end
        end
    endtask

    task automatic do_write(int sel, int data);
        @(negedge clk); wr_en = 1'b1; wr_sel = 4'(sel); wr_data = 8'(data);
        @(negedge clk); wr_en = 1'b0;
    endtask

    function automatic logic [7:0] abyte(int v, logic is_hour);
        if (v < 0) return 8'hC0 | 8'($urandom % 64);
        return is_hour ? 8'(enc_hour(v)) : 8'(enc(v));
    endfunction

    task automatic load_all();
        @(negedge clk); set_mode = 1'b1;
        do_write(0, enc(m_sec));  do_write(1, enc(m_min));  do_write(2, enc_hour(m_hr));
        do_write(3, enc(m_wday)); do_write(4, enc(m_mday)); do_write(5, enc(m_mon));
        do_write(6, enc(m_yr));   do_write(7, enc(m_cen));
        b_asec = abyte(a_sec, 1'b0); b_amin = abyte(a_min, 1'b0); b_ahr = abyte(a_hr, 1'b1);
        do_write(8, b_asec); do_write(9, b_amin); do_write(10, b_ahr);
        @(negedge clk); set_mode = 1'b0;
    endtask

    task automatic set_time(int h, int mi, int s, int wd, int d, int mo, int y, int c);
        m_hr = h; m_min = mi; m_sec = s; m_wday = wd; m_mday = d; m_mon = mo; m_yr = y; m_cen = c;
    endtask

    task automatic do_tick(string req);
        logic exp_alm;
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
        if (!set_mode) model_step();
        exp_alm = !set_mode && (a_sec < 0 || a_sec == m_sec) &&
                  (a_min < 0 || a_min == m_min) && (a_hr < 0 || a_hr == m_hr);
        check_all(req);
        chk(req, "update_pulse", update_pulse, !set_mode);
        chk(req, "alarm_pulse",  alarm_pulse,  exp_alm);
    endtask

    initial begin
        #600000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4177));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state, packed decimal 24-hour
        set_time(0, 0, 0, 1, 1, 1, 99, 20);
        a_sec = 0; a_min = 0; a_hr = 0; b_asec = 0; b_amin = 0; b_ahr = 0;
        check_all("R1");
        chk("R1", "update_pulse", update_pulse, 0);
        chk("R1", "alarm_pulse",  alarm_pulse,  0);

        do_tick("R2");
        @(negedge clk); chk("R10", "pulse width", update_pulse, 0);

        // R7 deepest carry, R5 weekday wrap
        set_time(23, 59, 59, 7, 31, 12, 99, 20); a_sec = -1; a_min = -1; a_hr = -1;
        load_all(); do_tick("R7");
        chk("R5", "wday wrap", wday_o, 1);
        set_time(23, 59, 59, 3, 28, 2, 24, 20); load_all(); do_tick("R6");
        set_time(23, 59, 59, 3, 28, 2, 23, 20); load_all(); do_tick("R6");
        set_time(23, 59, 59, 3, 30, 4, 23, 20); load_all(); do_tick("R6");
        set_time(23, 59, 59, 3, 31, 12, 99, 99); load_all(); do_tick("R7");
        set_time(5, 59, 59, 3, 9, 4, 23, 20);   load_all(); do_tick("R3");

        // R4 12-hour form
        fmt_24h = 1'b0;
        set_time(11, 59, 59, 2, 10, 5, 30, 20); a_sec = 5; a_min = -1; a_hr = -1;
        load_all(); do_tick("R4");
        chk("R4", "noon byte", hour_o, 8'h92);
        set_time(23, 59, 59, 2, 10, 5, 30, 20); load_all(); do_tick("R4");
        chk("R4", "midnight byte", hour_o, 8'h12);

        // R12 alarm hour with PM bit
        set_time(12, 59, 59, 2, 10, 5, 30, 20); a_sec = 0; a_min = 0; a_hr = 13;
        load_all(); do_tick("R12");
        chk("R12", "pm hit", alarm_pulse, 1);
        set_time(0, 59, 59, 2, 10, 5, 30, 20); load_all(); do_tick("R12");
        chk("R12", "am miss", alarm_pulse, 0);

        // R2 binary encoding, R11 all wildcards
        fmt_binary = 1'b1; fmt_24h = 1'b1;
        set_time(14, 59, 59, 6, 15, 8, 45, 20); a_sec = -1; a_min = -1; a_hr = -1;
        load_all(); do_tick("R2");
        chk("R2", "binary minute", min_o, 8'd0);
        do_tick("R11");
        chk("R11", "wild every update", alarm_pulse, 1);

        // R8 set mode freeze and held write
        @(negedge clk); set_mode = 1'b1;
        do_write(0, enc(30)); m_sec = 30;
        do_tick("R8");
        @(negedge clk); set_mode = 1'b0;
        do_tick("R8");

        // R9 unused select
        do_write(13, 8'h55);
        @(negedge clk); check_all("R9");
        do_write(15, 8'hAA);
        @(negedge clk); check_all("R9");

        // random rounds
        for (int i = 0; i < 60; i++) begin
            fmt_binary = 1'($urandom % 2);
            fmt_24h    = 1'($urandom % 2);
            m_cen  = $urandom % 100;
            m_yr   = ($urandom % 3 == 0) ? 99 : $urandom % 100;
            m_mon  = ($urandom % 3 == 0) ? 12 : 1 + $urandom % 12;
            m_mday = days_in(m_mon, m_yr) - ($urandom % 2);
            m_wday = 1 + $urandom % 7;
            m_hr   = ($urandom % 2) ? (($urandom % 2) ? 23 : 11) : $urandom % 24;
            m_min  = ($urandom % 2) ? 59 : $urandom % 60;
            m_sec  = 55 + $urandom % 5;
            a_sec  = ($urandom % 3 == 0) ? -1 : (m_sec + 1 + $urandom % 3) % 60;
            a_min  = ($urandom % 3 == 0) ? -1 : (($urandom % 2) ? m_min : (m_min + 1) % 60);
            a_hr   = ($urandom % 3 == 0) ? -1 : (($urandom % 2) ? m_hr : (m_hr + 1) % 24);
            load_all();
            for (int k = 0; k < 1 + int'($urandom % 5); k++) do_tick("R11");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule